// File: doc/BRIEF.md
# Palette Colour Lookup Register Interface

This block keeps a colour lookup table for an indexed-colour display. There are 256 pixel entries and 4 overlay entries, and each entry holds an 8-bit red, green and blue value. Software reaches the table through a small register window of 32-bit words. It first writes an entry number. It then streams colour components, one word per component, with the component in the top byte. After every third component, which is blue, the entry number advances by one.

A separate window offset reaches the four overlay entries. Accesses through it fold the entry number down to its two low bits and land after the pixel entries. Reads through a colour offset step through the same component sequence as writes, so software can read the table back. The display pipeline uses an independent combinational lookup port that turns a 9-bit entry number into a 24-bit colour.

Top module: `palette_dac`

## Requirements
- R1: After a synchronous active-high reset, every entry is black (0x000000), except entries 255, 256 and 258, which are white (0xFFFFFF). The entry number is 0 and the component phase is red.
- R2: A write at byte offset 0 loads the entry number from data bits 31:24 and returns the component phase to red.
- R3: A write at byte offset 4 stores data bits 31:24 into the entry selected by the entry number. Successive colour writes fill red, then green, then blue. Data bits 23:0 are ignored.
- R4: The colour access that completes the blue phase increments the entry number modulo 256 (255 wraps to 0) and returns the phase to red. No other colour access changes the entry number.
- R5: A write at byte offset 12 targets entry 256 plus entry-number bits 1:0. It uses the same component sequence and increment as offset 4, and it leaves the pixel entry with the same number untouched.
- R6: A read at byte offset 4 or 12 returns the current component of the entry named directly by the entry number. The component appears in bits 31:24 and bits 23:0 are zero. The read advances the phase exactly as a write would.
- R7: Writes at any other offset change no entry, no entry number and no phase. Reads at any other offset return zero and do not advance the phase.
- R8: The lookup port is combinational and returns {red[23:16], green[15:8], blue[7:0]}. A colour write to the looked-up entry becomes visible in the cycle after its clock edge. Lookup numbers above 259 return black.
- R9: Reads and writes at the colour offsets share one phase, so a read between two writes consumes a component slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dac_wr | input | 1 | Register write strobe (takes priority over dac_rd) |
| dac_rd | input | 1 | Register read strobe |
| dac_addr | input | 4 | Byte offset within the register window |
| dac_wdata | input | 32 | Write data; bits 31:24 carry the value |
| dac_rdata | output | 32 | Combinational read data for the current access |
| lut_idx | input | 9 | Display lookup entry number |
| lut_rgb | output | 24 | Colour of the looked-up entry |

## Verification
Component triples are written with distinct bytes and junk in the low 24 bits. This shows that the right byte lands in the right channel and that the low bits are dropped. Triples are also written at entry 255, which must wrap to 0, and through the overlay offset with a number whose low bits select a non-trivial overlay entry. That separates folding from direct indexing. Read-back runs, sequences that interleave reads and writes, repeated address loads in mid-triple, and accesses at an unused offset show how the shared phase advances and what leaves it alone. A lookup sampled on both sides of the blue write's clock edge pins down when a new value becomes visible.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int WORD_W   = 32;
    localparam int COMP_W   = 8;
    localparam int OFF_INDEX = 0;
    localparam int OFF_PIXEL = 4;
    localparam int OFF_OVRLY = 12;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] pick_comp(rgb_t c, phase_e p);
        case (p)
            PH_RED:  return c.red;
            PH_GRN:  return c.grn;
            default: return c.blu;
        endcase
    endfunction

    function automatic rgb_t reset_colour(int entry, int npix);
        rgb_t c;
        if (entry == npix - 1 || entry == npix || entry == npix + 2)
            c = '{red: '1, grn: '1, blu: '1};
        else
            c = '0;
        return c;
    endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            idx   <= load_val;
            phase <= PH_RED;
        end else if (step) begin
            if (phase == PH_BLU)
                idx <= idx + 1'b1;
            phase <= phase_after(phase);
        end
    end

endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int NUM_PIX = 256,
    parameter int NUM_OVL = 4,
    parameter int EA_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [EA_W-1:0]   waddr,
    input  phase_e            wphase,
    input  logic [COMP_W-1:0] wcomp,
    input  logic [EA_W-1:0]   raddr,
    output rgb_t              rcol,
    input  logic [EA_W-1:0]   laddr,
    output rgb_t              lcol
);

    localparam int NUM_ENT = NUM_PIX + NUM_OVL;

    rgb_t ent [NUM_ENT];

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[e] <= reset_colour(e, NUM_PIX);
            end else if (we && waddr == EA_W'(e)) begin
                case (wphase)
                    PH_RED:  ent[e].red <= wcomp;
                    PH_GRN:  ent[e].grn <= wcomp;
                    default: ent[e].blu <= wcomp;
                endcase
            end
        end
    end

    always_comb begin
        rcol = '0;
        lcol = '0;
        if (raddr < EA_W'(NUM_ENT))
            rcol = ent[raddr];
        if (laddr < EA_W'(NUM_ENT))
            lcol = ent[laddr];
    end

endmodule

// File: rtl/palette_dac.sv
module palette_dac
    import pal_pkg::*;
#(
    parameter int NUM_PIX = 256,
    parameter int NUM_OVL = 4,
    parameter int ADDR_W  = 4,
    localparam int IDX_W  = $clog2(NUM_PIX),
    localparam int OVL_W  = $clog2(NUM_OVL),
    localparam int EA_W   = $clog2(NUM_PIX + NUM_OVL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dac_wr,
    input  logic              dac_rd,
    input  logic [ADDR_W-1:0] dac_addr,
    input  logic [WORD_W-1:0] dac_wdata,
    output logic [WORD_W-1:0] dac_rdata,
    input  logic [EA_W-1:0]   lut_idx,
    output logic [23:0]       lut_rgb
);

    logic             at_index, at_pixel, at_ovrly, at_colour;
    logic             idx_load, col_wr, col_rd;
    logic [IDX_W-1:0] cur_idx;
    phase_e           cur_phase;
    logic [EA_W-1:0]  wr_entry;
    rgb_t             rd_col, lut_col;

    assign at_index  = dac_addr == ADDR_W'(OFF_INDEX);
    assign at_pixel  = dac_addr == ADDR_W'(OFF_PIXEL);
    assign at_ovrly  = dac_addr == ADDR_W'(OFF_OVRLY);
    assign at_colour = at_pixel | at_ovrly;

    assign idx_load = dac_wr & at_index;
    assign col_wr   = dac_wr & at_colour;
    assign col_rd   = dac_rd & ~dac_wr & at_colour;

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (idx_load),
        .load_val (dac_wdata[WORD_W-1 -: IDX_W]),
        .step     (col_wr | col_rd),
        .idx      (cur_idx),
        .phase    (cur_phase)
    );

    always_comb begin
        if (at_ovrly)
            wr_entry = EA_W'(NUM_PIX) + EA_W'(cur_idx[OVL_W-1:0]);
        else
            wr_entry = EA_W'(cur_idx);
    end

    pal_store #(.NUM_PIX(NUM_PIX), .NUM_OVL(NUM_OVL), .EA_W(EA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (col_wr),
        .waddr  (wr_entry),
        .wphase (cur_phase),
        .wcomp  (dac_wdata[WORD_W-1 -: COMP_W]),
        .raddr  (EA_W'(cur_idx)),
        .rcol   (rd_col),
        .laddr  (lut_idx),
        .lcol   (lut_col)
    );

    assign dac_rdata = col_rd ? {pick_comp(rd_col, cur_phase), {(WORD_W-COMP_W){1'b0}}}
                              : '0;
    assign lut_rgb   = lut_col;

endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              dac_wr,
    input logic              dac_rd,
    input logic [ADDR_W-1:0] dac_addr,
    input logic [31:0]       dac_wdata,
    input logic [31:0]       dac_rdata,
    input logic [IDX_W-1:0]  idx,
    input logic [1:0]        phase
);

    logic colour_off, other_off;
    assign colour_off = dac_addr == ADDR_W'(4) || dac_addr == ADDR_W'(12);
    assign other_off  = !colour_off && dac_addr != ADDR_W'(0);

    // R1
    phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3);

    // R2
    index_load_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_wr && dac_addr == ADDR_W'(0)) |=>
            (idx == $past(dac_wdata[31 -: IDX_W]) && phase == 2'd0));

    // R4
    blue_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ((dac_wr || dac_rd) && colour_off && phase == 2'd2) |=>
            (idx == IDX_W'($past(idx) + 1'b1) && phase == 2'd0));

    // R4
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((dac_wr || dac_rd) && colour_off && phase != 2'd2) |=>
            $stable(idx));

    // R7
    other_write_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_wr && other_off) |=> ($stable(idx) && $stable(phase)));

    // R7
    other_read_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_rd && !dac_wr && other_off) |-> dac_rdata == 32'd0);

    // R6
    read_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        dac_rdata[23:0] == 24'd0);

endmodule

bind palette_dac pal_dac_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_wr    (dac_wr),
    .dac_rd    (dac_rd),
    .dac_addr  (dac_addr),
    .dac_wdata (dac_wdata),
    .dac_rdata (dac_rdata),
    .idx       (cur_idx),
    .phase     (cur_phase)
);

// File: tb/test_palette_dac.sv
`timescale 1ns/1ps
module test_palette_dac;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dac_wr = 1'b0;
    logic        dac_rd = 1'b0;
    logic [3:0]  dac_addr = '0;
    logic [31:0] dac_wdata = '0;
    logic [31:0] dac_rdata;
    logic [8:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    palette_dac i_palette_dac (
        .clk(clk), .rst(rst), .dac_wr(dac_wr), .dac_rd(dac_rd),
        .dac_addr(dac_addr), .dac_wdata(dac_wdata), .dac_rdata(dac_rdata),
        .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        dac_addr = a; dac_wdata = d; dac_wr = 1'b1;
        @(posedge clk); #1;
        dac_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        dac_addr = a; dac_rd = 1'b1;
        #1 d = dac_rdata;
        @(posedge clk); #1;
        dac_rd = 1'b0;
    endtask

    task automatic look(string req, int e, logic [23:0] exp);
        @(negedge clk);
        lut_idx = 9'(e);
        #1 chk(req, {8'h0, lut_rgb}, {8'h0, exp});
    endtask

    task automatic triple(logic [3:0] a, logic [7:0] r, logic [7:0] g, logic [7:0] b);
        wr(a, {r, 24'h345678});
        wr(a, {g, 24'hABCDEF});
        wr(a, {b, 24'h135790});
    endtask

    task automatic t_reset();
        look("R1 entry0", 0, 24'h0);
        look("R1 entry100", 100, 24'h0);
        look("R1 entry255", 255, 24'hFFFFFF);
        look("R1 entry256", 256, 24'hFFFFFF);
        look("R1 entry257", 257, 24'h0);
        look("R1 entry258", 258, 24'hFFFFFF);
        look("R1 entry259", 259, 24'h0);
        look("R8 beyond range", 300, 24'h0);
        triple(4'd4, 8'h0A, 8'h0B, 8'h0C);
        look("R1 index starts at 0", 0, 24'h0A0B0C);
    endtask

    task automatic t_pixel();
        wr(4'd0, 32'h10FFFFFF);
        triple(4'd4, 8'h12, 8'h34, 8'h56);
        look("R3 pixel triple", 16, 24'h123456);
        triple(4'd4, 8'hAA, 8'hBB, 8'hCC);
        look("R4 next entry", 17, 24'hAABBCC);
        look("R3 neighbour untouched", 18, 24'h0);
    endtask

    task automatic t_wrap();
        wr(4'd0, 32'hFF000000);
        triple(4'd4, 8'h01, 8'h02, 8'h03);
        look("R4 entry255", 255, 24'h010203);
        triple(4'd4, 8'h04, 8'h05, 8'h06);
        look("R4 wrap to 0", 0, 24'h040506);
        look("R4 overlay not hit by wrap", 256, 24'hFFFFFF);
    endtask

    task automatic t_overlay();
        wr(4'd0, 32'h06000000);
        triple(4'd12, 8'h11, 8'h22, 8'h33);
        look("R5 overlay fold", 258, 24'h112233);
        look("R5 pixel entry untouched", 6, 24'h0);
        triple(4'd4, 8'h77, 8'h78, 8'h79);
        look("R5 index advanced", 7, 24'h777879);
    endtask

    task automatic t_read();
        logic [31:0] d;
        wr(4'd0, 32'h10000000);
        rd(4'd4, d); chk("R6 read red", d, 32'h12000000);
        rd(4'd4, d); chk("R6 read green", d, 32'h34000000);
        rd(4'd4, d); chk("R6 read blue", d, 32'h56000000);
        rd(4'd4, d); chk("R6 advance after blue", d, 32'hAA000000);
        wr(4'd0, 32'hFF000000);
        rd(4'd12, d); chk("R6 overlay offset reads direct", d, 32'h01000000);
    endtask

    task automatic t_other();
        logic [31:0] d;
        wr(4'd0, 32'h14000000);
        wr(4'd4, 32'h99000000);
        wr(4'd8, 32'hFFFFFFFF);
        rd(4'd8, d); chk("R7 other read zero", d, 32'h0);
        wr(4'd4, 32'h88000000);
        wr(4'd4, 32'h77000000);
        look("R7 other offset ignored", 20, 24'h998877);
        triple(4'd4, 8'h10, 8'h20, 8'h30);
        look("R7 index unchanged", 21, 24'h102030);
    endtask

    task automatic t_reload();
        wr(4'd0, 32'h1E000000);
        wr(4'd4, 32'h41000000);
        wr(4'd0, 32'h1E000000);
        triple(4'd4, 8'h51, 8'h52, 8'h53);
        look("R2 reload resets phase", 30, 24'h515253);
        look("R2 no advance", 31, 24'h0);
    endtask

    task automatic t_shared();
        logic [31:0] d;
        wr(4'd0, 32'h28000000);
        wr(4'd4, 32'h61000000);
        rd(4'd4, d); chk("R9 read consumes green", d, 32'h0);
        wr(4'd4, 32'h63000000);
        look("R9 shared phase", 40, 24'h610063);
        wr(4'd4, 32'h64000000);
        look("R9 advanced after mixed triple", 41, 24'h640000);
    endtask

    task automatic t_timing();
        wr(4'd0, 32'h32000000);
        wr(4'd4, 32'hA1000000);
        wr(4'd4, 32'hA2000000);
        @(negedge clk);
        lut_idx = 9'd50;
        dac_addr = 4'd4; dac_wdata = 32'hA3000000; dac_wr = 1'b1;
        #1 chk("R8 old value same cycle", {8'h0, lut_rgb}, 32'h00A1A200);
        @(posedge clk); #1;
        dac_wr = 1'b0;
        chk("R8 new value next cycle", {8'h0, lut_rgb}, 32'h00A1A2A3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_pixel();
        t_wrap();
        t_overlay();
        t_read();
        t_other();
        t_reload();
        t_shared();
        t_timing();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule